// File: doc/BRIEF.md
# Double-Precision to Signed Integer Converter

This block turns a 64-bit IEEE 754 double into a 64-bit two's-complement integer under a chosen rounding mode. It suits the integer-conversion slot of a floating-point unit. When the value does not fit, the output is the low 64 bits of the exact integer, not a clamped value. Software can then use the same result as an unsigned conversion, and a separate flag reports the overflow.

Each request carries the operand, a two-bit rounding mode, a chop control that forces truncation, and a flush control that treats subnormal inputs as zero. One clock after a request strobe, the result is presented with three flags: invalid input, integer overflow and inexact. Between requests the output holds its last value.

Top module: `d2i_convert`

## Requirements
- R1: `out_vld` is high in exactly the cycles that follow a cycle with `in_vld` high. Result and flags are captured only on `in_vld`, and they hold otherwise. Reset clears `out_vld`, the result and all flags.
- R2: An input with exponent field 0, a nonzero fraction and `in_ftz` low returns 0 with `out_inv` set and the other flags clear.
- R3: An input with exponent field 0 returns 0 with no flags when the fraction is zero (either sign). It also does so for a nonzero fraction when `in_ftz` is high.
- R4: An input with exponent field all ones (infinity or NaN) returns 0 with only `out_inv` set.
- R5: When the unbiased exponent is 52 or more and below 63, the result is the exact integer and no flag is set.
- R6: When the unbiased exponent is 63 or more, both `out_iov` and `out_ine` are set. The result is the low 64 bits of the exact integer. The single exception is operand 0xC3E0000000000000 (-2^63), which returns 0x8000000000000000 with no flags.
- R7: Mode 2'b00 rounds to nearest. A discarded part of exactly one half rounds to the even integer, and one above one half rounds away from zero.
- R8: Mode 2'b01 truncates toward zero. `in_chop` high forces truncation whatever `in_rmode` holds.
- R9: Mode 2'b10 rounds toward minus infinity, and mode 2'b11 rounds toward plus infinity.
- R10: `out_ine` is set whenever nonzero bits are discarded. This includes values so small that every mantissa bit lies below the binary point, which still count as nonzero for directed rounding.
- R11: Negative inputs give the two's-complement negation of the rounded magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Request strobe |
| in_op | input | 64 | Double-precision operand |
| in_rmode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| in_chop | input | 1 | Force truncation toward zero |
| in_ftz | input | 1 | Treat subnormal inputs as zero |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| out_int | output | 64 | Two's-complement integer result |
| out_inv | output | 1 | Invalid input flag |
| out_iov | output | 1 | Integer overflow flag |
| out_ine | output | 1 | Inexact flag |

## Verification
The operands are chosen so that each one separates a pair of rounding rules:
- Halfway values with an even and an odd integer part separate round-to-even from round-half-up.
- Values just above a half test the plain round-up case.
- Tie values pushed through all four modes, with both signs, show each direction.

The boundary set covers:
- The smallest normal number under round-up, which tests the sticky fallback.
- 2^62, which is just under the overflow threshold.
- 2^63 and 2^64, which show the wrapped result.
- -2^63 exactly, and a negative value just beyond it, which distinguish the special case from true overflow.
- Infinity, NaN, subnormals with and without flushing, and negative zero.

// File: rtl/d2i_pkg.sv
package d2i_pkg;
   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'b00,
      RM_TO_ZERO   = 2'b01,
      RM_DOWN      = 2'b10,
      RM_UP        = 2'b11
   } rmode_e;

   typedef enum logic [1:0] {
      CLS_ZERO   = 2'b00,
      CLS_NORMAL = 2'b01,
      CLS_BAD    = 2'b10
   } opclass_e;
endpackage

// File: rtl/d2i_classify.sv
module d2i_classify
   import d2i_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
   input  logic [OP_W-1:0]   op,
   input  logic              ftz,
   output logic              sign,
   output logic [EXP_W-1:0]  expo,
   output logic [FRAC_W:0]   mant,
   output opclass_e          cls
);
   logic [FRAC_W-1:0] frac;

   assign sign = op[OP_W-1];
   assign expo = op[OP_W-2 -: EXP_W];
   assign frac = op[FRAC_W-1:0];
   assign mant = {1'b1, frac};

   always_comb begin
      if (expo == '0) begin
         cls = ((frac != '0) && !ftz) ? CLS_BAD : CLS_ZERO;   // R2 R3
      end else if (expo == '1) begin
         cls = CLS_BAD;                                       // R4
      end else begin
         cls = CLS_NORMAL;
      end
   end
endmodule

// File: rtl/d2i_align.sv
module d2i_align #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int INT_W  = 64
) (
   input  logic [EXP_W-1:0]  expo,
   input  logic [FRAC_W:0]   mant,
   input  logic              is_min,
   output logic [INT_W-1:0]  mag,
   output logic [INT_W-1:0]  rnd,
   output logic              ovf
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam logic [EXP_W-1:0] UNIT_EXP  = EXP_W'(BIAS + FRAC_W);
   localparam logic [EXP_W-1:0] OVF_SHIFT = EXP_W'(INT_W - 1 - FRAC_W);
   localparam logic [EXP_W-1:0] INT_W_E   = EXP_W'(INT_W);

   generate
      if (INT_W < FRAC_W + 2) begin : g_bad_width
         $error("d2i_align: INT_W must exceed the mantissa width");
      end
   endgenerate

   logic [INT_W-1:0] mant_w;
   logic [EXP_W-1:0] lsh;
   logic [EXP_W-1:0] rsh;

   assign mant_w = {{(INT_W - FRAC_W - 1){1'b0}}, mant};
   assign lsh    = expo - UNIT_EXP;
   assign rsh    = UNIT_EXP - expo;

   always_comb begin
      mag = '0;
      rnd = '0;
      ovf = 1'b0;
      if (expo >= UNIT_EXP) begin
         mag = mant_w << lsh;                          // R5 exact left shift
         ovf = (lsh >= OVF_SHIFT) && !is_min;          // R6
      end else if (rsh >= INT_W_E) begin
         mag = '0;
         rnd = {{(INT_W-1){1'b0}}, 1'b1};              // R10 sticky fallback
      end else begin
         mag = mant_w >> rsh;
         rnd = mant_w << (INT_W_E - rsh);
      end
   end
endmodule

// File: rtl/d2i_round.sv
module d2i_round
   import d2i_pkg::*;
#(
   parameter int INT_W = 64
) (
   input  logic [INT_W-1:0] mag,
   input  logic [INT_W-1:0] rnd,
   input  logic             sign,
   input  rmode_e           mode,
   output logic [INT_W-1:0] mag_r,
   output logic             inexact
);
   localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};

   logic inc;
   logic any_rnd;

   assign any_rnd = |rnd;
   assign inexact = any_rnd;                          // R10

   always_comb begin
      unique case (mode)
         RM_NEAR_EVEN: inc = (rnd > HALF) || ((rnd == HALF) && mag[0]);   // R7
         RM_TO_ZERO:   inc = 1'b0;                                        // R8
         RM_DOWN:      inc = sign && any_rnd;                             // R9
         RM_UP:        inc = !sign && any_rnd;                            // R9
         default:      inc = 1'b0;
      endcase
   end

   assign mag_r = mag + {{(INT_W-1){1'b0}}, inc};
endmodule

// File: rtl/d2i_convert.sv
module d2i_convert
   import d2i_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int INT_W  = 64,
   localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [OP_W-1:0]   in_op,
   input  logic [1:0]        in_rmode,
   input  logic              in_chop,
   input  logic              in_ftz,
   output logic              out_vld,
   output logic [INT_W-1:0]  out_int,
   output logic              out_inv,
   output logic              out_iov,
   output logic              out_ine
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam logic [OP_W-1:0] MIN_PAT =
      {1'b1, EXP_W'(BIAS + INT_W - 1), {FRAC_W{1'b0}}};

   generate
      if (EXP_W < 2 || FRAC_W < 1) begin : g_bad_fmt
         $error("d2i_convert: format widths too small");
      end
   endgenerate

   logic             sign;
   logic [EXP_W-1:0] expo;
   logic [FRAC_W:0]  mant;
   opclass_e         cls;
   logic [INT_W-1:0] mag, rnd, mag_r;
   logic             ovf, inexact;
   rmode_e           mode_eff;
   logic [INT_W-1:0] nxt_int;
   logic             nxt_inv, nxt_iov, nxt_ine;

   assign mode_eff = in_chop ? RM_TO_ZERO : rmode_e'(in_rmode);   // R8

   d2i_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op(in_op), .ftz(in_ftz), .sign(sign), .expo(expo), .mant(mant), .cls(cls)
   );

   d2i_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
      .expo(expo), .mant(mant), .is_min(in_op == MIN_PAT),
      .mag(mag), .rnd(rnd), .ovf(ovf)
   );

   d2i_round #(.INT_W(INT_W)) u_round (
      .mag(mag), .rnd(rnd), .sign(sign), .mode(mode_eff),
      .mag_r(mag_r), .inexact(inexact)
   );

   always_comb begin
      nxt_int = '0;
      nxt_inv = 1'b0;
      nxt_iov = 1'b0;
      nxt_ine = 1'b0;
      unique case (cls)
         CLS_BAD:    nxt_inv = 1'b1;
         CLS_NORMAL: begin
            nxt_int = sign ? ('0 - mag_r) : mag_r;     // R11
            nxt_iov = ovf;
            nxt_ine = ovf | inexact;
         end
         default:    nxt_int = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_int <= '0;
         out_inv <= 1'b0;
         out_iov <= 1'b0;
         out_ine <= 1'b0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_int <= nxt_int;
            out_inv <= nxt_inv;
            out_iov <= nxt_iov;
            out_ine <= nxt_ine;
         end
      end
   end

   AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);                                                   // R1
   AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld);                                                 // R1
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(out_int));                                         // R1
   AST_INV_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      out_inv |-> (out_int == '0) && !out_iov && !out_ine);                  // R2
   AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && (in_op[OP_W-2:0] == '0) |=> (out_int == '0) && !out_inv && !out_ine); // R3
   AST_NONFINITE: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && (in_op[OP_W-2 -: EXP_W] == '1) |=> out_inv);                 // R4
   AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
      out_iov |-> out_ine);                                                  // R6
endmodule

// File: tb/d2i_convert_test.sv
`timescale 1ns/1ps
module d2i_convert_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [63:0] in_op = '0;
   logic [1:0]  in_rmode = '0;
   logic        in_chop = 1'b0;
   logic        in_ftz = 1'b0;
   logic        out_vld;
   logic [63:0] out_int;
   logic        out_inv, out_iov, out_ine;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   d2i_convert uut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
      .in_rmode(in_rmode), .in_chop(in_chop), .in_ftz(in_ftz),
      .out_vld(out_vld), .out_int(out_int),
      .out_inv(out_inv), .out_iov(out_iov), .out_ine(out_ine)
   );

   // {operand, mode, chop, ftz, expected int, expected {inv,iov,ine}}
   localparam int NV = 28;
   localparam logic [134:0] VEC [NV] = '{
      {64'h3FF0000000000000, 2'b00, 1'b0, 1'b0, 64'h0000000000000001, 3'b000}, // R5 1.0
      {64'hBFF0000000000000, 2'b00, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 3'b000}, // R11 -1.0
      {64'h4004000000000000, 2'b00, 1'b0, 1'b0, 64'h0000000000000002, 3'b001}, // R7 2.5 tie even
      {64'h400C000000000000, 2'b00, 1'b0, 1'b0, 64'h0000000000000004, 3'b001}, // R7 3.5 tie odd
      {64'h3FF8000000000000, 2'b00, 1'b0, 1'b0, 64'h0000000000000002, 3'b001}, // R7 1.5
      {64'h3FE0000000000000, 2'b00, 1'b0, 1'b0, 64'h0000000000000000, 3'b001}, // R7 0.5
      {64'h4006000000000000, 2'b00, 1'b0, 1'b0, 64'h0000000000000003, 3'b001}, // R7 2.75
      {64'h4004000000000000, 2'b01, 1'b0, 1'b0, 64'h0000000000000002, 3'b001}, // R8 rtz
      {64'h400C000000000000, 2'b00, 1'b1, 1'b0, 64'h0000000000000003, 3'b001}, // R8 chop over nearest
      {64'h4004000000000000, 2'b11, 1'b1, 1'b0, 64'h0000000000000002, 3'b001}, // R8 chop over up
      {64'hC004000000000000, 2'b10, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFD, 3'b001}, // R9 -2.5 down
      {64'hC004000000000000, 2'b11, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFE, 3'b001}, // R9 -2.5 up
      {64'h4004000000000000, 2'b11, 1'b0, 1'b0, 64'h0000000000000003, 3'b001}, // R9 2.5 up
      {64'h4004000000000000, 2'b10, 1'b0, 1'b0, 64'h0000000000000002, 3'b001}, // R9 2.5 down
      {64'h3FD0000000000000, 2'b00, 1'b0, 1'b0, 64'h0000000000000000, 3'b001}, // R10 0.25
      {64'h0010000000000000, 2'b11, 1'b0, 1'b0, 64'h0000000000000001, 3'b001}, // R10 sticky up
      {64'h8010000000000000, 2'b10, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 3'b001}, // R10 sticky down
      {64'h43E0000000000000, 2'b00, 1'b0, 1'b0, 64'h8000000000000000, 3'b011}, // R6 2^63
      {64'hC3E0000000000000, 2'b00, 1'b0, 1'b0, 64'h8000000000000000, 3'b000}, // R6 -2^63 exact
      {64'h43F0000000000000, 2'b00, 1'b0, 1'b0, 64'h0000000000000000, 3'b011}, // R6 2^64 wraps
      {64'hC3E0000000000001, 2'b00, 1'b0, 1'b0, 64'h7FFFFFFFFFFFF800, 3'b011}, // R6 below -2^63
      {64'h43D0000000000000, 2'b00, 1'b0, 1'b0, 64'h4000000000000000, 3'b000}, // R5 2^62
      {64'h43D8000000000000, 2'b00, 1'b0, 1'b0, 64'h6000000000000000, 3'b000}, // R5 1.5*2^62
      {64'h4330000000000000, 2'b00, 1'b0, 1'b0, 64'h0010000000000000, 3'b000}, // R5 2^52
      {64'h7FF0000000000000, 2'b00, 1'b0, 1'b0, 64'h0000000000000000, 3'b100}, // R4 inf
      {64'hFFF8000000000000, 2'b11, 1'b0, 1'b0, 64'h0000000000000000, 3'b100}, // R4 NaN
      {64'h0000000000000001, 2'b11, 1'b0, 1'b0, 64'h0000000000000000, 3'b100}, // R2 subnormal
      {64'h0000000000000001, 2'b11, 1'b0, 1'b1, 64'h0000000000000000, 3'b000}  // R3 flushed
   };
   localparam int VREQ [NV] = '{5, 11, 7, 7, 7, 7, 7, 8, 8, 8, 9, 9, 9, 9,
                                10, 10, 10, 6, 6, 6, 6, 5, 5, 5, 4, 4, 2, 3};

   task automatic check(input string req, input logic [63:0] gi, input logic [2:0] gf,
                        input logic gv, input logic [63:0] ei, input logic [2:0] ef,
                        input logic ev);
      checks++;
      if (gi !== ei || gf !== ef || gv !== ev) begin
         errors++;
         $display("FAIL %s: got int=%h flags=%b vld=%b, expected int=%h flags=%b vld=%b",
                  req, gi, gf, gv, ei, ef, ev);
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got no finish, expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] held;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", out_int, {out_inv, out_iov, out_ine}, out_vld, 64'h0, 3'b000, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) begin
         logic [134:0] v;
         v = VEC[i];
         in_op    = v[134:71];
         in_rmode = v[70:69];
         in_chop  = v[68];
         in_ftz   = v[67];
         in_vld   = 1'b1;
         @(negedge clk);
         check($sformatf("R%0d vec%0d", VREQ[i], i), out_int,
               {out_inv, out_iov, out_ine}, out_vld, v[66:3], v[2:0], 1'b1);
      end
      // R1: output drops and holds with new operand presented but no strobe
      held = out_int;
      in_vld = 1'b0;
      in_op  = 64'h3FF0000000000000;
      @(negedge clk);
      check("R1 idle", out_int, {out_inv, out_iov, out_ine}, out_vld, held, 3'b000, 1'b0);
      @(negedge clk);
      check("R1 hold", out_int, {out_inv, out_iov, out_ine}, out_vld, held, 3'b000, 1'b0);
      // R3 negative zero, after a gap
      in_op = 64'h8000000000000000;
      in_rmode = 2'b10;
      in_vld = 1'b1;
      @(negedge clk);
      check("R3 neg zero", out_int, {out_inv, out_iov, out_ine}, out_vld, 64'h0, 3'b000, 1'b1);
      in_vld = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule